// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Day-End Strobe

This block keeps a 24-hour time of day as three packed BCD fields: hours, minutes and seconds. A fractional phase register adds a programmable rate word on every system clock. Each carry out of its top bit is one second. On that cycle the block raises a one-cycle second tick, and the time fields advance with decimal carries. The rate word's reset value is computed from a clock-frequency parameter, so the default gives exactly one second at the nominal clock. Software can change the rate word to trim the block, or to speed it up.

On the last second of the day (23:59:59), the second tick also drives a day-end strobe. The next tick is then the first second of the new day, so a calendar counter wired to the strobe changes date on the same edge on which the clock wraps to midnight. A small word-wide bus slave reads and writes the time and the rate word. A write to the time leaves any field whose 8-bit write value is all ones unchanged. A capture input takes a snapshot of the time and the phase register, which software can read back later.

Top module: `tod_clock`

## Requirements
- R1: The phase register is FRAC_W bits wide, split into a lower LOW_W-bit part and an upper part. It adds the rate word every clock. `sec_tick_o` is high in exactly the cycles whose add overflows 2^FRAC_W, so a rate of 2^FRAC_W/N gives one tick every N cycles.
- R2: The reset is asynchronous and active low, and its release takes effect after two rising edges. Reset clears the time to 00:00:00 and the phase register to zero. It loads the rate word with round(2^FRAC_W / CLK_HZ) and holds `bus_ack_o` and `day_pulse_o` low.
- R3: The time register keeps seconds in bits 7:0, minutes in bits 15:8 and hours in bits 21:16, with all other bits reading as zero. Each tick advances the seconds. Seconds roll from 59 to 00 and carry into the minutes. Minutes roll from 59 to 00 and carry into the hours. Hours roll from 23 to 00. Between ticks and writes the time holds.
- R4: `day_pulse_o` is high for one cycle, only in a cycle where the tick is high and the time reads 23:59:59. After that edge the time reads 00:00:00.
- R5: A write to address 0 takes write-data bits 7:0 as seconds, 15:8 as minutes and bits 21:16 as hours, with bits 23:16 as the hours field value. A field whose 8-bit value is 0xFF keeps its contents. A bus write to a field wins over a tick in the same cycle.
- R6: A time field that holds a non-decimal digit, or a value above its limit (59 for minutes and seconds, 23 for hours), reads 00 from the edge after the write.
- R7: Address 1 reads and writes the rate word. A rate of zero stops the phase register and the tick.
- R8: A high `hack_i` copies the time into a snapshot on the next edge. The snapshot reads at address 2. Address 3 returns the upper 32 bits of the copied phase register, left-aligned.
- R9: `bus_ack_o` is `bus_cyc_i` AND `bus_stb_i` delayed by one clock. `bus_rdata_o` is valid while ack is high. `bus_stall_o` is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_cyc_i | input | 1 | Bus cycle |
| bus_stb_i | input | 1 | Bus strobe |
| bus_we_i | input | 1 | Bus write enable |
| bus_addr_i | input | 2 | Word address: 0 time, 1 rate, 2 snapshot time, 3 snapshot phase |
| bus_wdata_i | input | 32 | Write data |
| bus_ack_o | output | 1 | Acknowledge, one cycle after request |
| bus_stall_o | output | 1 | Always low |
| bus_rdata_o | output | 32 | Read data, valid with ack |
| hack_i | input | 1 | Snapshot request strobe |
| sec_tick_o | output | 1 | One-cycle second tick |
| day_pulse_o | output | 1 | Day-end strobe for a calendar counter |

## Verification
The tick and the day-end strobe are combinational from the phase and time registers, so they appear in the overflow cycle itself. The time fields change on the following edge. Ack and read data arrive one edge after the request. A write, a rate change or a snapshot takes effect on the edge that samples it, and an illegal field clears one edge after that. The bench drives inputs and samples outputs at the falling edge, and counts ticks and strobes in a monitor. Before it reads the time back, it writes a rate of zero to stop the clock. Every tick it counted has then already reached the time register, so the expected time is the start value plus that count.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;

  typedef struct packed {
    logic [5:0] hr;
    logic [7:0] mn;
    logic [7:0] sc;
  } tod_t;

  localparam int unsigned TOD_W = 22;

  localparam logic [1:0] REG_TIME  = 2'd0;
  localparam logic [1:0] REG_RATE  = 2'd1;
  localparam logic [1:0] REG_HTIME = 2'd2;
  localparam logic [1:0] REG_HFRAC = 2'd3;

  localparam logic [7:0] FIELD_KEEP = 8'hFF;
  localparam logic [7:0] SEC_LAST   = 8'h59;
  localparam logic [7:0] MIN_LAST   = 8'h59;
  localparam logic [7:0] HR_LAST    = 8'h23;

  // two BCD digits, each decimal, and no larger than the limit
  function automatic logic bcd2_ok(input logic [7:0] v, input logic [7:0] lim);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v <= lim);
  endfunction

  // next two-digit BCD value, wrapping to zero after lim
  function automatic logic [7:0] bcd2_next(input logic [7:0] v, input logic [7:0] lim);
    logic [7:0] r;
    if (v == lim)            r = 8'h00;
    else if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                     r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

endpackage

// File: rtl/tod_phase_acc.sv
`timescale 1ns/1ps
module tod_phase_acc #(
  parameter int unsigned FRAC_W = 48,
  parameter int unsigned LOW_W  = 40,
  parameter int unsigned STEP_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] step_i,
  output logic [FRAC_W-1:0] acc_o,
  output logic              tick_o
);
  localparam int unsigned HI_W = FRAC_W - LOW_W;

  logic [LOW_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic [LOW_W:0]   lo_sum;
  logic [HI_W:0]    hi_sum;
  logic             acc_en;

  always_comb begin
    lo_sum = {1'b0, lo_q} + (LOW_W+1)'(step_i);
    hi_sum = {1'b0, hi_q} + (HI_W+1)'(lo_sum[LOW_W]);
    lo_d   = lo_sum[LOW_W-1:0];
    hi_d   = hi_sum[HI_W-1:0];
    acc_en = (step_i != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (acc_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign acc_o  = {hi_q, lo_q};
  assign tick_o = acc_en & hi_sum[HI_W];

endmodule

// File: rtl/tod_time_core.sv
`timescale 1ns/1ps
module tod_time_core
  import tod_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_i,
  input  logic [23:0] wdata_i,
  output tod_t        time_o,
  output logic        last_sec_o
);
  tod_t time_q, time_d;
  logic sc_ok, mn_ok, hr_ok;
  logic inc_sc, inc_mn, inc_hr;
  logic wr_sc, wr_mn, wr_hr;
  logic [7:0] hr_next;
  logic upd_en;

  always_comb begin
    sc_ok  = bcd2_ok(time_q.sc, SEC_LAST);
    mn_ok  = bcd2_ok(time_q.mn, MIN_LAST);
    hr_ok  = bcd2_ok({2'b00, time_q.hr}, HR_LAST);

    inc_sc = tick_i;
    inc_mn = inc_sc && (time_q.sc == SEC_LAST);
    inc_hr = inc_mn && (time_q.mn == MIN_LAST);

    wr_sc  = wr_i && (wdata_i[7:0]   != FIELD_KEEP);
    wr_mn  = wr_i && (wdata_i[15:8]  != FIELD_KEEP);
    wr_hr  = wr_i && (wdata_i[23:16] != FIELD_KEEP);

    hr_next = bcd2_next({2'b00, time_q.hr}, HR_LAST);

    time_d = time_q;

    if (wr_sc)       time_d.sc = wdata_i[7:0];
    else if (!sc_ok) time_d.sc = 8'h00;
    else if (inc_sc) time_d.sc = bcd2_next(time_q.sc, SEC_LAST);

    if (wr_mn)       time_d.mn = wdata_i[15:8];
    else if (!mn_ok) time_d.mn = 8'h00;
    else if (inc_mn) time_d.mn = bcd2_next(time_q.mn, MIN_LAST);

    if (wr_hr)       time_d.hr = wdata_i[21:16];
    else if (!hr_ok) time_d.hr = 6'h00;
    else if (inc_hr) time_d.hr = hr_next[5:0];

    upd_en = tick_i || wr_i || !(sc_ok && mn_ok && hr_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_q <= '0;
    else if (upd_en) time_q <= time_d;
  end

  assign time_o     = time_q;
  assign last_sec_o = (time_q.hr == HR_LAST[5:0]) && (time_q.mn == MIN_LAST)
                      && (time_q.sc == SEC_LAST);

endmodule

// File: rtl/tod_bus_regs.sv
`timescale 1ns/1ps
module tod_bus_regs
  import tod_pkg::*;
#(
  parameter int unsigned FRAC_W = 48,
  parameter int unsigned STEP_W = 32,
  parameter logic [STEP_W-1:0] RATE_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  tod_t              time_i,
  input  logic [FRAC_W-1:0] acc_i,
  input  logic              hack_i,
  output logic              ack_o,
  output logic [31:0]       rdata_o,
  output logic [STEP_W-1:0] rate_o,
  output logic              time_wr_o,
  output tod_t              hack_time_o
);
  logic              req, rate_wr;
  logic [STEP_W-1:0] rate_q;
  tod_t              htime_q;
  logic [FRAC_W-1:0] hfrac_q;
  logic [31:0]       frac_top, rd_rate, rd_mux, rdata_q;
  logic              ack_q;

  generate
    if (FRAC_W >= 32) begin : g_frac_wide
      assign frac_top = hfrac_q[FRAC_W-1 -: 32];
    end else begin : g_frac_narrow
      assign frac_top = {hfrac_q, {(32-FRAC_W){1'b0}}};
    end
  endgenerate

  always_comb begin
    req       = cyc_i && stb_i;
    rate_wr   = req && we_i && (addr_i == REG_RATE);
    time_wr_o = req && we_i && (addr_i == REG_TIME);
    rd_rate   = '0;
    rd_rate[STEP_W-1:0] = rate_q;
    case (addr_i)
      REG_TIME:  rd_mux = {{(32-TOD_W){1'b0}}, time_i};
      REG_RATE:  rd_mux = rd_rate;
      REG_HTIME: rd_mux = {{(32-TOD_W){1'b0}}, htime_q};
      default:   rd_mux = frac_top;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rate_q <= RATE_RST;
    else if (rate_wr) rate_q <= wdata_i[STEP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      htime_q <= '0;
      hfrac_q <= '0;
    end else if (hack_i) begin
      htime_q <= time_i;
      hfrac_q <= acc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= req;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (req) rdata_q <= rd_mux;
  end

  assign ack_o       = ack_q;
  assign rdata_o     = rdata_q;
  assign rate_o      = rate_q;
  assign hack_time_o = htime_q;

endmodule

// File: rtl/tod_clock.sv
`timescale 1ns/1ps
module tod_clock
  import tod_pkg::*;
#(
  parameter int unsigned FRAC_W = 48,
  parameter int unsigned LOW_W  = 40,
  parameter int unsigned STEP_W = 32,
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_cyc_i,
  input  logic        bus_stb_i,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic        bus_ack_o,
  output logic        bus_stall_o,
  output logic [31:0] bus_rdata_o,
  input  logic        hack_i,
  output logic        sec_tick_o,
  output logic        day_pulse_o
);
  localparam logic [63:0] RATE_FULL =
    ((64'd1 << FRAC_W) + 64'(CLK_HZ / 2)) / 64'(CLK_HZ);
  localparam logic [STEP_W-1:0] RATE_NOM = RATE_FULL[STEP_W-1:0];

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [STEP_W-1:0] rate;
  logic [FRAC_W-1:0] acc;
  logic              tick, last_sec, time_wr;
  tod_t              cur_time, hack_time;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  tod_phase_acc #(.FRAC_W(FRAC_W), .LOW_W(LOW_W), .STEP_W(STEP_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .step_i(rate), .acc_o(acc), .tick_o(tick)
  );

  tod_time_core u_time (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .tick_i(tick), .wr_i(time_wr),
    .wdata_i(bus_wdata_i[23:0]), .time_o(cur_time), .last_sec_o(last_sec)
  );

  tod_bus_regs #(.FRAC_W(FRAC_W), .STEP_W(STEP_W), .RATE_RST(RATE_NOM)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .cyc_i(bus_cyc_i), .stb_i(bus_stb_i),
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .time_i(cur_time),
    .acc_i(acc), .hack_i(hack_i), .ack_o(bus_ack_o), .rdata_o(bus_rdata_o),
    .rate_o(rate), .time_wr_o(time_wr), .hack_time_o(hack_time)
  );

  assign bus_stall_o = 1'b0;
  assign sec_tick_o  = tick;
  assign day_pulse_o = tick & last_sec;

endmodule

// File: rtl/tod_clock_chk.sv
`timescale 1ns/1ps
module tod_clock_chk
  import tod_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cyc_i,
  input logic       stb_i,
  input logic       we_i,
  input logic [1:0] addr_i,
  input logic       ack_i,
  input logic       tick_i,
  input logic       day_i,
  input logic       hack_i,
  input tod_t       time_i,
  input tod_t       hack_time_i
);
  logic twr, legal;
  assign twr   = cyc_i && stb_i && we_i && (addr_i == REG_TIME);
  assign legal = bcd2_ok(time_i.sc, SEC_LAST) && bcd2_ok(time_i.mn, MIN_LAST)
                 && bcd2_ok({2'b00, time_i.hr}, HR_LAST);

  a_r9_ack_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && stb_i) |=> ack_i);
  a_r9_no_ack_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cyc_i && stb_i) |=> !ack_i);
  a_r4_midnight_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_i && !twr) |=> (time_i == '0));
  a_r4_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_i |=> !day_i);
  a_r4_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_i |-> tick_i);
  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !twr && legal) |=> $stable(time_i));
  a_r6_clear_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!twr && !bcd2_ok(time_i.sc, SEC_LAST)) |=> (time_i.sc == 8'h00));
  a_r8_snapshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hack_i |=> (hack_time_i == $past(time_i)));

endmodule

bind tod_clock tod_clock_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_sync_n), .cyc_i(bus_cyc_i), .stb_i(bus_stb_i),
  .we_i(bus_we_i), .addr_i(bus_addr_i), .ack_i(bus_ack_o), .tick_i(sec_tick_o),
  .day_i(day_pulse_o), .hack_i(hack_i), .time_i(cur_time), .hack_time_i(hack_time)
);

// File: tb/tod_clock_tb.sv
`timescale 1ns/1ps
module tod_clock_tb;
  localparam int unsigned FW = 12, LW = 11, SW = 11, HZ = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0, hack = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic ack, stall, tick, day;
  logic [31:0] rdata;

  int errors = 0, checks = 0;
  int tick_cnt = 0, ppd_cnt = 0;

  always #2.5 clk = ~clk;

  tod_clock #(.FRAC_W(FW), .LOW_W(LW), .STEP_W(SW), .CLK_HZ(HZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_ack_o(ack), .bus_stall_o(stall),
    .bus_rdata_o(rdata), .hack_i(hack), .sec_tick_o(tick), .day_pulse_o(day)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (tick) tick_cnt++;
      if (day)  ppd_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tod_adv(input logic [31:0] t, input int n);
    int h, m, s, tot;
    h = t[21:20] * 10 + t[19:16];
    m = t[15:12] * 10 + t[11:8];
    s = t[7:4] * 10 + t[3:0];
    tot = (h * 3600 + m * 60 + s + n) % 86400;
    h = tot / 3600; m = (tot / 60) % 60; s = tot % 60;
    return {10'd0, 2'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  task automatic xfer(input logic w, input logic [1:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    chk("R9 ack one cycle after request", {31'd0, ack}, 32'd1);
    chk("R9 stall low", {31'd0, stall}, 32'd0);
    rd = rdata;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] unused;
    xfer(1'b1, a, d, unused);
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    xfer(1'b0, a, 32'd0, v);
    chk(req, v, exp);
  endtask

  // run at a rate for n cycles, stop the clock, return ticks counted
  task automatic run(input logic [31:0] rate, input int n, output int ticks);
    int c0;
    #1 c0 = tick_cnt;
    wr(2'd1, rate);
    repeat (n) @(negedge clk);
    wr(2'd1, 32'd0);
    #1 ticks = tick_cnt - c0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R2 ack low after reset", {31'd0, ack}, 32'd0);
    chk("R2 day pulse low after reset", {31'd0, day}, 32'd0);
    repeat (2) @(negedge clk);
    rd_chk("R2 time cleared", 2'd0, 32'h0);
    rd_chk("R2 nominal rate", 2'd1, 32'h400);
    wr(2'd1, 32'd0);
  endtask

  task automatic t_rate();
    int a, b;
    wr(2'd1, 32'h200);
    rd_chk("R7 rate readback", 2'd1, 32'h200);
    #1 a = tick_cnt;
    repeat (64) @(negedge clk);
    #1 b = tick_cnt;
    chk("R1 one tick per 8 cycles", b - a, 32'd8);
    wr(2'd1, 32'h400);
    #1 a = tick_cnt;
    repeat (64) @(negedge clk);
    #1 b = tick_cnt;
    chk("R1 one tick per 4 cycles", b - a, 32'd16);
    wr(2'd1, 32'd0);
    #1 a = tick_cnt;
    repeat (20) @(negedge clk);
    #1 b = tick_cnt;
    chk("R7 zero rate stops ticks", b - a, 32'd0);
  endtask

  task automatic t_carry(input logic [31:0] start);
    int n;
    wr(2'd0, start);
    rd_chk("R5 time written", 2'd0, start);
    run(32'h7FF, 30, n);
    chk("R3 enough ticks for carry", {31'd0, n >= 3}, 32'd1);
    rd_chk("R3 BCD carry chain", 2'd0, tod_adv(start, n));
  endtask

  task automatic t_midnight();
    int n, p0;
    chk("R4 no strobe before day end", ppd_cnt, 32'd0);
    wr(2'd0, 32'h235950);
    #1 p0 = ppd_cnt;
    run(32'h7FF, 60, n);
    chk("R4 exactly one day-end strobe", ppd_cnt - p0, 32'd1);
    rd_chk("R4 wrap past midnight", 2'd0, tod_adv(32'h235950, n));
  endtask

  task automatic t_keep();
    wr(2'd0, 32'h00123456);
    rd_chk("R5 full write", 2'd0, 32'h123456);
    wr(2'd0, 32'h00FFFF07);
    rd_chk("R5 seconds only", 2'd0, 32'h123407);
    wr(2'd0, 32'h00FF45FF);
    rd_chk("R5 minutes only", 2'd0, 32'h124507);
    wr(2'd0, 32'h0021FFFF);
    rd_chk("R5 hours only", 2'd0, 32'h214507);
  endtask

  task automatic t_sanitize();
    wr(2'd0, 32'h00FFFF5A);
    rd_chk("R6 bad seconds digit cleared", 2'd0, 32'h214500);
    wr(2'd0, 32'h0024FFFF);
    rd_chk("R6 hours above 23 cleared", 2'd0, 32'h004500);
    wr(2'd0, 32'h00FF6011);
    rd_chk("R6 minutes above 59 cleared", 2'd0, 32'h000011);
  endtask

  task automatic t_hack();
    wr(2'd0, 32'h00134211);
    @(negedge clk); hack = 1'b1;
    @(negedge clk); hack = 1'b0;
    wr(2'd0, 32'h00010203);
    rd_chk("R8 snapshot time", 2'd2, 32'h134211);
    rd_chk("R8 live time unaffected", 2'd0, 32'h010203);
  endtask

  task automatic t_bus_idle();
    rd_chk("R9 read data with ack", 2'd1, 32'h0);
    @(negedge clk);
    chk("R9 ack drops when idle", {31'd0, ack}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_rate();
    t_carry(32'h095958);
    t_carry(32'h195959);
    t_midnight();
    t_keep();
    t_sanitize();
    t_hack();
    t_bus_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule